// File: doc/BRIEF.md
# Hardwired Instruction-Cycle Control Sequencer

This block is the control unit and register set of a small accumulator processor. It runs every instruction as a fixed series of clocked steps, grouped into subcycles: fetch, an optional indirect subcycle, execute, and an optional interrupt subcycle. In each step the hardwired decoder enables one micro-operation or a group of micro-operations that can run in parallel. The registers are the program counter, the memory address and memory buffer registers, the instruction register, the accumulator and one general register.

The block drives a single-word synchronous memory port. The address is always the memory address register and the write data is always the memory buffer register. The port has separate read and write strobes. Read data must be valid while the read strobe is high, and it is captured at the next clock edge. An interrupt request is sampled only as the execute subcycle completes. When the request is taken, the interrupt subcycle stores the program counter at a fixed save address and continues at a fixed handler address. Debug outputs report the current subcycle and step.

Top module: `instr_cycle_ctrl`

## Requirements
- R1: While rst_n is low at a rising edge, the block returns to fetch step 0. The program counter, accumulator, general register and instruction register clear to 0, both strobes are low, and interrupts are enabled.
- R2: Fetch takes three steps. Step 0 copies the program counter into the address register. Step 1 raises the read strobe, captures the read data into the buffer and increments the program counter. Step 2 copies the buffer into the instruction register. The buffer is never filled from memory in the same step that it is read into the instruction register, and the read and write strobes are never high together.
- R3: The instruction word is bit 7 = indirect flag, bits 6:4 = opcode and bits 3:0 = address. Opcode 0 adds into the accumulator, 2 adds into the general register, 1 is increment-and-skip-if-zero and 7 is halt. Every other opcode is a single execute step that changes nothing.
- R4: When the indirect flag is set, a three-step subcycle follows fetch. It loads the address register from the address field, reads memory, and replaces the address field with the low 4 bits of the word read. Execute then proceeds as for a direct operand.
- R5: An add takes three execute steps: address from the field, a memory read, then target = target + operand modulo 256.
- R6: Increment-and-skip takes four execute steps: address, read, buffer + 1, then a write of the incremented value to the same address. In that last step the program counter is incremented if the incremented value is 0.
- R7: The interrupt request has an effect only when it is high at the edge that ends an execute subcycle and interrupts are enabled. Taking an interrupt clears the enable, so later requests are ignored.
- R8: The interrupt subcycle takes three steps. Step 0 copies the zero-extended program counter into the buffer. Step 1 sets the address register to 0x0 and the program counter to 0x1. Step 2 writes the buffer to memory. Fetch follows.
- R9: After a halt executes, the block stays in the halted subcycle. No strobes are raised, registers hold their values and interrupt requests are ignored until reset.
- R10: dbg_subcycle reports fetch=0, indirect=1, execute=2, interrupt=3, halted=4. dbg_step reports the step within the subcycle, from 0 to 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq | input | 1 | Interrupt request level |
| mem_rdata | input | 8 | Memory read data for the current address |
| mem_addr | output | 4 | Memory address (address register) |
| mem_wdata | output | 8 | Memory write data (buffer register) |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe, memory stores on the rising edge |
| pc_o | output | 4 | Program counter |
| ac_o | output | 8 | Accumulator |
| r1_o | output | 8 | General register |
| ir_o | output | 8 | Instruction register |
| halted | output | 1 | High in the halted subcycle |
| dbg_subcycle | output | 3 | Current subcycle code |
| dbg_step | output | 2 | Current step within the subcycle |

## Verification
The hardest case to reach from the ports is an interrupt request that is high at exactly the edge that closes an execute subcycle, together with requests that arrive at other times and must have no effect. The stimulus takes its timing from the bench's own cycle model. It first pulses the request during a fetch, then raises it on the single-step execute of a no-op opcode. It then holds the request high through the handler and the halt, so that clearing the enable is what keeps a second interrupt from starting. The program also makes increment-and-skip wrap to zero and take the skip. It also reads a pointer word whose upper bits are non-zero, so the indirect subcycle must replace only the address field.

// File: rtl/icc_pkg.sv
`timescale 1ns/1ps
// Package: shared types and constants of the instruction-cycle sequencer.
// Assumes an instruction word of {indirect, opcode, address}.
package icc_pkg;
    localparam int OP_W   = 3;
    localparam int STEP_W = 2;

    typedef enum logic [2:0] {
        SC_FETCH = 3'd0,
        SC_INDIR = 3'd1,
        SC_EXEC  = 3'd2,
        SC_INTR  = 3'd3,
        SC_HALT  = 3'd4
    } subcycle_e;

    localparam logic [OP_W-1:0] OP_ADD_AC = 3'd0;
    localparam logic [OP_W-1:0] OP_ISZ    = 3'd1;
    localparam logic [OP_W-1:0] OP_ADD_R1 = 3'd2;
    localparam logic [OP_W-1:0] OP_HALT   = 3'd7;

    // Per-step enables for the datapath
    typedef struct packed {
        logic mar_pc;
        logic mar_ir;
        logic mar_save;
        logic mbr_mem;
        logic mbr_pc;
        logic mbr_inc;
        logic pc_inc;
        logic pc_handler;
        logic pc_skip;
        logic ir_load;
        logic ir_addr_load;
        logic ac_add;
        logic r1_add;
        logic ie_clear;
        logic mem_rd;
        logic mem_wr;
    } ctl_t;

    // Index of the final execute step for an opcode
    function automatic logic [STEP_W-1:0] exec_last(input logic [OP_W-1:0] op);
        case (op)
            OP_ADD_AC, OP_ADD_R1: exec_last = 2'd2;
            OP_ISZ:               exec_last = 2'd3;
            default:              exec_last = 2'd0;
        endcase
    endfunction

    // True for opcodes that fetch a memory operand
    function automatic logic has_operand(input logic [OP_W-1:0] op);
        has_operand = (op == OP_ADD_AC) || (op == OP_ADD_R1) || (op == OP_ISZ);
    endfunction
endpackage

// File: rtl/icc_sequencer.sv
`timescale 1ns/1ps
// Module: icc_sequencer
// Steps the subcycle/step state. Fetch chooses indirect or execute from
// the flag bit of the word in the buffer. Execute ends at an opcode-dependent
// step and then goes to halt, interrupt or fetch.
// Assumes: op is stable for the whole indirect and execute subcycles.
module icc_sequencer
    import icc_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [OP_W-1:0]       op,
    input  logic                  ind_flag,
    input  logic                  irq,
    input  logic                  ie,
    output subcycle_e             sub_q,
    output logic [STEP_W-1:0]     step_q
);
    logic exec_done;
    assign exec_done = (sub_q == SC_EXEC) && (step_q == exec_last(op));

    // Purpose: advance the step counter and choose the next subcycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sub_q  <= SC_FETCH;
            step_q <= '0;
        end else begin
            case (sub_q)
                SC_FETCH: begin
                    if (step_q == 2'd2) begin
                        sub_q  <= ind_flag ? SC_INDIR : SC_EXEC;
                        step_q <= '0;
                    end else begin
                        step_q <= step_q + 1'b1;
                    end
                end
                SC_INDIR: begin
                    if (step_q == 2'd2) begin
                        sub_q  <= SC_EXEC;
                        step_q <= '0;
                    end else begin
                        step_q <= step_q + 1'b1;
                    end
                end
                SC_EXEC: begin
                    if (exec_done) begin
                        step_q <= '0;
                        if (op == OP_HALT)      sub_q <= SC_HALT;
                        else if (irq && ie)     sub_q <= SC_INTR;
                        else                    sub_q <= SC_FETCH;
                    end else begin
                        step_q <= step_q + 1'b1;
                    end
                end
                SC_INTR: begin
                    if (step_q == 2'd2) begin
                        sub_q  <= SC_FETCH;
                        step_q <= '0;
                    end else begin
                        step_q <= step_q + 1'b1;
                    end
                end
                default: begin
                    sub_q  <= SC_HALT;
                    step_q <= '0;
                end
            endcase
        end
    end

    // R4: the indirect subcycle starts only straight after a fetch
    assert_indir_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sub_q == SC_INDIR && step_q == 2'd0) |-> ($past(sub_q) == SC_FETCH));

    // R7: the interrupt subcycle starts only from an execute end with request and enable
    assert_intr_entry_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (sub_q == SC_INTR && step_q == 2'd0) |->
            ($past(sub_q) == SC_EXEC && $past(irq) && $past(ie)));

    // R10: three-step subcycles never report step 3
    assert_step_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (sub_q != SC_EXEC) |-> (step_q <= 2'd2));
endmodule

// File: rtl/icc_decode.sv
`timescale 1ns/1ps
// Module: icc_decode
// Hardwired step decoder. Maps (subcycle, step, opcode) onto the set of
// micro-operations that run in parallel in that step.
// Assumes: purely combinational; the sequencer supplies legal states.
module icc_decode
    import icc_pkg::*;
(
    input  subcycle_e         sub,
    input  logic [STEP_W-1:0] step,
    input  logic [OP_W-1:0]   op,
    output ctl_t              ctl
);
    // Purpose: raise the enables for the current step
    always_comb begin
        ctl = '0;
        case (sub)
            SC_FETCH: begin
                case (step)
                    2'd0: ctl.mar_pc = 1'b1;
                    2'd1: begin
                        ctl.mem_rd  = 1'b1;
                        ctl.mbr_mem = 1'b1;
                        ctl.pc_inc  = 1'b1;
                    end
                    2'd2: ctl.ir_load = 1'b1;
                    default: ;
                endcase
            end
            SC_INDIR: begin
                case (step)
                    2'd0: ctl.mar_ir = 1'b1;
                    2'd1: begin
                        ctl.mem_rd  = 1'b1;
                        ctl.mbr_mem = 1'b1;
                    end
                    2'd2: ctl.ir_addr_load = 1'b1;
                    default: ;
                endcase
            end
            SC_EXEC: begin
                if (has_operand(op)) begin
                    case (step)
                        2'd0: ctl.mar_ir = 1'b1;
                        2'd1: begin
                            ctl.mem_rd  = 1'b1;
                            ctl.mbr_mem = 1'b1;
                        end
                        2'd2: begin
                            if (op == OP_ISZ)         ctl.mbr_inc = 1'b1;
                            else if (op == OP_ADD_AC) ctl.ac_add  = 1'b1;
                            else                      ctl.r1_add  = 1'b1;
                        end
                        2'd3: begin
                            if (op == OP_ISZ) begin
                                ctl.mem_wr  = 1'b1;
                                ctl.pc_skip = 1'b1;
                            end
                        end
                        default: ;
                    endcase
                end
            end
            SC_INTR: begin
                case (step)
                    2'd0: ctl.mbr_pc = 1'b1;
                    2'd1: begin
                        ctl.mar_save   = 1'b1;
                        ctl.pc_handler = 1'b1;
                        ctl.ie_clear   = 1'b1;
                    end
                    2'd2: ctl.mem_wr = 1'b1;
                    default: ;
                endcase
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/icc_datapath.sv
`timescale 1ns/1ps
// Module: icc_datapath
// Holds PC, MAR, MBR, IR, AC, the general register and the interrupt
// enable, and applies the enables of one step per clock.
// Assumes: the decoder never enables two sources for one register.
module icc_datapath
    import icc_pkg::*;
#(
    parameter int                ADDR_W       = 4,
    parameter int                DATA_W       = ADDR_W + OP_W + 1,
    parameter logic [ADDR_W-1:0] SAVE_ADDR    = '0,
    parameter logic [ADDR_W-1:0] HANDLER_ADDR = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  ctl_t              ctl,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] pc_q,
    output logic [ADDR_W-1:0] mar_q,
    output logic [DATA_W-1:0] mbr_q,
    output logic [DATA_W-1:0] ir_q,
    output logic [DATA_W-1:0] ac_q,
    output logic [DATA_W-1:0] r1_q,
    output logic              ie_q
);
    localparam int EXT_W = DATA_W - ADDR_W;

    logic mbr_zero;
    assign mbr_zero = (mbr_q == '0);

    // Purpose: program counter - fetch increment, handler load, skip
    always_ff @(posedge clk) begin
        if (!rst_n)                      pc_q <= '0;
        else if (ctl.pc_inc)             pc_q <= pc_q + 1'b1;
        else if (ctl.pc_handler)         pc_q <= HANDLER_ADDR;
        else if (ctl.pc_skip && mbr_zero) pc_q <= pc_q + 1'b1;
    end

    // Purpose: memory address register from PC, IR field or save address
    always_ff @(posedge clk) begin
        if (!rst_n)            mar_q <= '0;
        else if (ctl.mar_pc)   mar_q <= pc_q;
        else if (ctl.mar_ir)   mar_q <= ir_q[ADDR_W-1:0];
        else if (ctl.mar_save) mar_q <= SAVE_ADDR;
    end

    // Purpose: memory buffer from memory, from PC, or incremented
    always_ff @(posedge clk) begin
        if (!rst_n)           mbr_q <= '0;
        else if (ctl.mbr_mem) mbr_q <= mem_rdata;
        else if (ctl.mbr_pc)  mbr_q <= {{EXT_W{1'b0}}, pc_q};
        else if (ctl.mbr_inc) mbr_q <= mbr_q + 1'b1;
    end

    // Purpose: instruction register, whole word or address field only
    always_ff @(posedge clk) begin
        if (!rst_n)                ir_q <= '0;
        else if (ctl.ir_load)      ir_q <= mbr_q;
        else if (ctl.ir_addr_load) ir_q[ADDR_W-1:0] <= mbr_q[ADDR_W-1:0];
    end

    // Purpose: accumulator and general register adders
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ac_q <= '0;
            r1_q <= '0;
        end else begin
            if (ctl.ac_add) ac_q <= ac_q + mbr_q;
            if (ctl.r1_add) r1_q <= r1_q + mbr_q;
        end
    end

    // Purpose: interrupt enable, set by reset and cleared on entry
    always_ff @(posedge clk) begin
        if (!rst_n)            ie_q <= 1'b1;
        else if (ctl.ie_clear) ie_q <= 1'b0;
    end

    // R2: the IR is loaded only in the step after the buffer was filled from memory
    assert_ir_after_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.ir_load |-> $past(ctl.mbr_mem));

    // R8: handler entry leaves PC at the handler, MAR at the save slot, enable clear
    assert_handler_entry_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.pc_handler |=> (pc_q == HANDLER_ADDR) && (mar_q == SAVE_ADDR) && !ie_q);

    // R6: a skip never happens on a non-zero incremented value
    assert_no_false_skip_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl.pc_skip && !mbr_zero) |=> $stable(pc_q));
endmodule

// File: rtl/instr_cycle_ctrl.sv
`timescale 1ns/1ps
// Module: instr_cycle_ctrl (top)
// Hardwired control unit with its register set: sequencer, step decoder and
// datapath. The memory port address is MAR and the write data is MBR.
// Assumes: mem_rdata is valid for mem_addr while mem_rd is high; memory
// stores mem_wdata on the rising edge while mem_wr is high.
module instr_cycle_ctrl
    import icc_pkg::*;
#(
    parameter int                ADDR_W       = 4,
    parameter logic [ADDR_W-1:0] SAVE_ADDR    = '0,
    parameter logic [ADDR_W-1:0] HANDLER_ADDR = 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         irq,
    input  logic [ADDR_W+OP_W:0]         mem_rdata,
    output logic [ADDR_W-1:0]            mem_addr,
    output logic [ADDR_W+OP_W:0]         mem_wdata,
    output logic                         mem_rd,
    output logic                         mem_wr,
    output logic [ADDR_W-1:0]            pc_o,
    output logic [ADDR_W+OP_W:0]         ac_o,
    output logic [ADDR_W+OP_W:0]         r1_o,
    output logic [ADDR_W+OP_W:0]         ir_o,
    output logic                         halted,
    output logic [2:0]                   dbg_subcycle,
    output logic [STEP_W-1:0]            dbg_step
);
    localparam int DATA_W = ADDR_W + OP_W + 1;

    subcycle_e          sub;
    logic [STEP_W-1:0]  step;
    ctl_t               ctl;
    logic [ADDR_W-1:0]  pc_q, mar_q;
    logic [DATA_W-1:0]  mbr_q, ir_q, ac_q, r1_q;
    logic               ie_q;
    logic [OP_W-1:0]    op;

    assign op = ir_q[DATA_W-2 -: OP_W];

    icc_sequencer u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .op       (op),
        .ind_flag (mbr_q[DATA_W-1]),
        .irq      (irq),
        .ie       (ie_q),
        .sub_q    (sub),
        .step_q   (step)
    );

    icc_decode u_dec (
        .sub  (sub),
        .step (step),
        .op   (op),
        .ctl  (ctl)
    );

    icc_datapath #(
        .ADDR_W       (ADDR_W),
        .DATA_W       (DATA_W),
        .SAVE_ADDR    (SAVE_ADDR),
        .HANDLER_ADDR (HANDLER_ADDR)
    ) u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl       (ctl),
        .mem_rdata (mem_rdata),
        .pc_q      (pc_q),
        .mar_q     (mar_q),
        .mbr_q     (mbr_q),
        .ir_q      (ir_q),
        .ac_q      (ac_q),
        .r1_q      (r1_q),
        .ie_q      (ie_q)
    );

    assign mem_addr     = mar_q;
    assign mem_wdata    = mbr_q;
    assign mem_rd       = ctl.mem_rd;
    assign mem_wr       = ctl.mem_wr;
    assign pc_o         = pc_q;
    assign ac_o         = ac_q;
    assign r1_o         = r1_q;
    assign ir_o         = ir_q;
    assign halted       = (sub == SC_HALT);
    assign dbg_subcycle = sub;
    assign dbg_step     = step;

    // R2: read and write strobes are never high together
    assert_rd_wr_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    // R9: once halted, the port is quiet and the registers hold
    assert_halt_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (halted && $past(halted)) |->
            (!mem_rd && !mem_wr && $stable(pc_o) && $stable(ac_o) && $stable(r1_o)));
endmodule

// File: tb/instr_cycle_ctrl_tb.sv
`timescale 1ns/1ps
// Bench: a behavioural cycle model runs next to the DUT and is compared on
// every falling edge; final register and memory contents are also checked.
module instr_cycle_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       irq = 1'b0;
    logic [7:0] mem_rdata;
    logic [3:0] mem_addr;
    logic [7:0] mem_wdata;
    logic       mem_rd, mem_wr;
    logic [3:0] pc_o;
    logic [7:0] ac_o, r1_o, ir_o;
    logic       halted;
    logic [2:0] dbg_subcycle;
    logic [1:0] dbg_step;

    always #2.5 clk = ~clk;

    instr_cycle_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .irq(irq), .mem_rdata(mem_rdata),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .pc_o(pc_o), .ac_o(ac_o), .r1_o(r1_o), .ir_o(ir_o), .halted(halted),
        .dbg_subcycle(dbg_subcycle), .dbg_step(dbg_step)
    );

    // memory seen by the DUT
    logic [7:0] dmem [16];
    assign mem_rdata = dmem[mem_addr];
    always @(posedge clk) if (mem_wr) dmem[mem_addr] <= mem_wdata;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    bit live     = 0;
    bit done     = 0;

    // reference model state
    int mm [16];
    int m_sub, m_step, m_pc, m_mar, m_mbr, m_ir, m_ac, m_r1, m_ie;
    bit m_rst;

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    function automatic int m_op();
        return (m_ir >> 4) & 7;
    endfunction

    function automatic int last_step(input int op);
        if (op == 0 || op == 2) return 2;
        if (op == 1) return 3;
        return 0;
    endfunction

    function automatic string phase_tag();
        if (m_rst) return "R1";
        case (m_sub)
            0: return "R2";
            1: return "R4";
            2: begin
                case (m_op())
                    0, 2: return "R5";
                    1:    return "R6";
                    7:    return "R9";
                    default: return "R3";
                endcase
            end
            3: return "R8";
            default: return "R9";
        endcase
    endfunction

    // model: one step per rising edge
    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_sub = 0; m_step = 0; m_pc = 0; m_mar = 0; m_mbr = 0;
            m_ir = 0; m_ac = 0; m_r1 = 0; m_ie = 1; m_rst = 1;
        end else begin
            m_rst = 0;
            case (m_sub)
                0: begin
                    if (m_step == 0) begin m_mar = m_pc; m_step = 1; end
                    else if (m_step == 1) begin m_mbr = mm[m_mar]; m_pc = (m_pc + 1) % 16; m_step = 2; end
                    else begin m_ir = m_mbr; m_step = 0; m_sub = (m_ir >= 128) ? 1 : 2; end
                end
                1: begin
                    if (m_step == 0) begin m_mar = m_ir % 16; m_step = 1; end
                    else if (m_step == 1) begin m_mbr = mm[m_mar]; m_step = 2; end
                    else begin m_ir = (m_ir & 8'hF0) | (m_mbr % 16); m_step = 0; m_sub = 2; end
                end
                2: begin
                    int op;
                    op = m_op();
                    if (op == 0 || op == 1 || op == 2) begin
                        if (m_step == 0) m_mar = m_ir % 16;
                        else if (m_step == 1) m_mbr = mm[m_mar];
                        else if (m_step == 2) begin
                            if (op == 1) m_mbr = (m_mbr + 1) % 256;
                            else if (op == 0) m_ac = (m_ac + m_mbr) % 256;
                            else m_r1 = (m_r1 + m_mbr) % 256;
                        end else begin
                            mm[m_mar] = m_mbr;
                            if (m_mbr == 0) m_pc = (m_pc + 1) % 16;
                        end
                    end
                    if (m_step == last_step(op)) begin
                        m_step = 0;
                        if (op == 7) m_sub = 4;
                        else if (irq && m_ie == 1) m_sub = 3;
                        else m_sub = 0;
                    end else m_step++;
                end
                3: begin
                    if (m_step == 0) begin m_mbr = m_pc; m_step = 1; end
                    else if (m_step == 1) begin m_mar = 0; m_pc = 1; m_ie = 0; m_step = 2; end
                    else begin mm[m_mar] = m_mbr; m_step = 0; m_sub = 0; end
                end
                default: ;
            endcase
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (live && !done) begin
            string t;
            int exp_rd, exp_wr, op;
            t  = phase_tag();
            op = m_op();
            exp_rd = ((m_sub == 0 || m_sub == 1) && m_step == 1) ||
                     (m_sub == 2 && (op == 0 || op == 1 || op == 2) && m_step == 1);
            exp_wr = (m_sub == 2 && op == 1 && m_step == 3) || (m_sub == 3 && m_step == 2);
            chk(m_rst ? "R1" : "R10", "subcycle", dbg_subcycle, m_sub);
            chk(m_rst ? "R1" : "R10", "step", dbg_step, m_step);
            chk(t, "mem_rd", mem_rd, exp_rd);
            chk(t, "mem_wr", mem_wr, exp_wr);
            if (exp_rd || exp_wr) chk(t, "mem_addr", mem_addr, m_mar);
            if (exp_wr) chk(t, "mem_wdata", mem_wdata, m_mbr);
            chk(t, "pc", pc_o, m_pc);
            chk(t, "ac", ac_o, m_ac);
            chk(t, "r1", r1_o, m_r1);
            chk(t, "ir", ir_o, m_ir);
            chk(m_sub == 4 ? "R9" : t, "halted", halted, (m_sub == 4) ? 1 : 0);
        end
    end

    // watchdog
    always @(posedge clk) begin
        if (cyc > 20000 && !done) begin
            done = 1;
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: actual hung run expected completion (cycle %0d)", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int prog [16];
        prog = '{8'h0A, 8'h1B, 8'h70, 8'h8C, 8'h2D, 8'h1E, 8'h30, 8'h70,
                 8'h00, 8'h00, 8'h25, 8'hFF, 8'h4D, 8'h11, 8'h05, 8'h00};
        for (int i = 0; i < 16; i++) begin
            dmem[i] = prog[i][7:0];
            mm[i]   = prog[i];
        end
        repeat (3) @(negedge clk);
        // R1: reset state at the ports
        chk("R1", "pc", pc_o, 0);
        chk("R1", "ac", ac_o, 0);
        chk("R1", "r1", r1_o, 0);
        chk("R1", "subcycle", dbg_subcycle, 0);
        chk("R1", "strobes", {mem_rd, mem_wr}, 0);
        live = 1;
        rst_n = 1;
        // R7: a request during a fetch has no effect
        do @(negedge clk); while (!(m_sub == 0 && m_step == 2 && m_pc == 4));
        irq = 1;
        repeat (2) @(negedge clk);
        irq = 0;
        // R7: request raised on the single-step execute of opcode 3
        do @(negedge clk); while (!(m_sub == 2 && m_op() == 3));
        irq = 1;
        do @(negedge clk); while (m_sub != 3);
        // held high from here: enable is clear, so it must be ignored
        do @(negedge clk); while (m_sub != 4);
        repeat (6) @(negedge clk);
        chk("R5", "final ac", ac_o, 8'h36);
        chk("R5", "final r1", r1_o, 8'h11);
        chk("R9", "final pc", pc_o, 3);
        chk("R3", "final ir", ir_o, 8'h70);
        chk("R8", "saved pc at 0x0", dmem[0], 8'h07);
        chk("R7", "single interrupt, save slot", dmem[0], mm[0]);
        chk("R6", "wrapped then bumped word", dmem[11], 8'h01);
        chk("R6", "incremented word", dmem[14], 8'h06);
        chk("R4", "pointer word unchanged", dmem[12], 8'h4D);
        for (int i = 0; i < 16; i++) chk("R6", "memory image", dmem[i], mm[i]);
        chk("R9", "halted", halted, 1);
        // R1: reset again from the halted state
        irq = 0;
        rst_n = 0;
        repeat (2) @(negedge clk);
        chk("R1", "pc after reset", pc_o, 0);
        chk("R1", "subcycle after reset", dbg_subcycle, 0);
        chk("R1", "halted after reset", halted, 0);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule